// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block is the receiving half of a slave-mode serial audio port. An external bit clock, a frame sync and one serial data line come in. The block turns the serial stream into parallel samples, one per slot, each marked with a valid strobe and a slot index. With two-channel framing, slot 0 is the left channel and slot 1 is the right. With pulse framing, slots 0 up to the last slot follow one after another.

Several framing choices are made at run time. These are the bit-clock edge on which data is taken, the frame-sync transition that opens a frame, and the number of bit clocks between that transition and the first data bit. The slot length and the word length are also set at run time. One block therefore covers I2S (falling sync start, offset 1), left-justified (rising sync start, offset 0) and TDM with a one-clock sync pulse.

The block also counts bit clocks between frame starts. It reports whether that count is a supported ratio and whether it has held steady. All logic runs on the bit clock, and reset is synchronous.

Top module: `sap_rx`

## Requirements
- R1: After reset `smp_valid`, `ratio_lock` and `ratio_err` are 0 and `ratio_val` is 0. No sample is produced while the frame sync never makes a frame-start transition.
- R2: With `cfg_fall_edge`=0, data and sync are taken on the rising bit-clock edge. Bits arrive MSB first. Each word appears left-aligned in the 32-bit `smp_data`, with the first slot of a frame reported as `smp_slot`=0 and the next as 1.
- R3: With `cfg_fall_edge`=1, data and sync are taken on the falling bit-clock edge, and the received words are the same as in R2.
- R4: `cfg_fs_rise`=1 makes a 0-to-1 sync transition the frame start, and `cfg_offset`=0 places the first data bit in the same bit clock as that transition (left-justified).
- R5: `cfg_offset`=2 places the first data bit two bit clocks after the frame-start transition. A word may run past the next frame start by up to the offset.
- R6: Bit positions at or beyond `cfg_word_len` within a slot are ignored, and the matching low bits of `smp_data` are 0.
- R7: With a one-clock sync pulse, slots of `cfg_slot_len` bits follow back to back after the offset, and `smp_slot` counts up by one per slot.
- R8: `smp_valid` is high for exactly one bit clock per completed slot.
- R9: `ratio_val` gives the bit clocks between the last two frame starts. `ratio_lock` rises once two consecutive frames have the same count and that count is one of 32, 48, 64, 128 or 256.
- R10: A frame length outside the supported set sets `ratio_err` and keeps `ratio_lock` at 0.
- R11: A frame length that differs from the previous one sets `ratio_err` and clears `ratio_lock`. `ratio_lock` and `ratio_err` are never high together.
- R12: Slot length and word length are taken up only at the first data bit after a frame start. A change made partway through a frame leaves the rest of that frame's words unaffected.
- R13: At most 8 slots are output per frame. Any further slots are dropped until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync from the transmitter |
| sdata | input | 1 | Serial data, MSB first |
| cfg_fall_edge | input | 1 | 1: take data on the falling bit-clock edge; 0: rising |
| cfg_fs_rise | input | 1 | 1: rising sync transition starts a frame; 0: falling |
| cfg_offset | input | 2 | Bit clocks from frame start to first data bit |
| cfg_slot_len | input | 6 | Bit clocks per slot |
| cfg_word_len | input | 6 | Significant bits per slot, not above slot length |
| smp_valid | output | 1 | One-clock strobe for a completed sample |
| smp_slot | output | 3 | Slot index of the sample |
| smp_data | output | 32 | Left-aligned sample, unused low bits zero |
| ratio_val | output | 9 | Last measured bit clocks per frame |
| ratio_lock | output | 1 | Supported ratio seen on two consecutive frames |
| ratio_err | output | 1 | Ratio unsupported, changed, or sync lost |

## Verification
The hardest case to reach is a word that crosses a frame boundary. When the offset is non-zero, the last slot of a frame ends only after the next frame start has been seen. A configuration change near that point must not reach the word that is still being received. The bench produces these cases with a stream generator that counts bits across the whole stream, not frame by frame, so data for the final slot naturally spills into the next frame. The same generator can change the word length at a chosen bit inside a frame. The ratio-change case is reached by joining two streams of different frame lengths without a reset in between.

// File: rtl/sap_pkg.sv
// Shared types and helpers for the serial audio receiver.
// Assumes: frame ratios are compared as plain integers.
package sap_pkg;

    // One sampled bit-clock period: sync level and data level.
    typedef struct packed {
        logic fs;
        logic sd;
    } sap_bit_t;

    // True for the bit-clock-per-frame counts the ratio meter accepts.
    function automatic bit ratio_ok(input int n);
        return (n == 32) || (n == 48) || (n == 64) || (n == 128) || (n == 256);
    endfunction

endpackage

// File: rtl/sap_bit_capture.sv
// Picks the bit-clock edge on which sync and data are taken, and finds frame
// starts. On the falling-edge setting, a negative-edge register holds the
// pair until the next rising edge. That keeps every consumer in the rising-edge
// domain with the same one-edge latency for both settings.
// Assumes: fsync and sdata change only on the edge opposite the chosen one.
module sap_bit_capture
    import sap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fsync,
    input  logic     sdata,
    input  logic     fall_edge,
    input  logic     fs_rise,
    output sap_bit_t cur,
    output logic     frame_start
);

    sap_bit_t neg_q;
    logic     fs_prev_q;
    logic     prev_vld_q;

    // Take the pair on the falling edge for the falling-edge setting.
    always_ff @(negedge clk) begin
        if (!rst_n) neg_q <= '0;
        else        neg_q <= '{fs: fsync, sd: sdata};
    end

    // Choose the pair for this bit period.
    always_comb begin
        cur = fall_edge ? neg_q : sap_bit_t'{fs: fsync, sd: sdata};
    end

    // Remember the previous sync level once one bit has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_prev_q  <= 1'b0;
            prev_vld_q <= 1'b0;
        end else begin
            fs_prev_q  <= cur.fs;
            prev_vld_q <= 1'b1;
        end
    end

    // A frame starts on a sync transition toward the selected level.
    assign frame_start = prev_vld_q && (cur.fs != fs_prev_q) && (cur.fs == fs_rise);

endmodule

// File: rtl/sap_ratio_meter.sv
// Counts bit clocks between frame starts. It reports the count, whether two
// consecutive counts matched a supported value, and when the count is
// unsupported, changes, or runs past MAX_RATIO without a frame start.
// Assumes: frame_start is a single-cycle flag in the bit-clock domain.
module sap_ratio_meter
    import sap_pkg::*;
#(
    parameter int RATIO_W   = 9,
    parameter int MAX_RATIO = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    output logic [RATIO_W-1:0] ratio_val,
    output logic               ratio_lock,
    output logic               ratio_err
);

    logic [RATIO_W-1:0] run_q;
    logic [RATIO_W-1:0] meas;
    logic               have_start_q;
    logic               have_meas_q;

    assign meas = run_q + RATIO_W'(1);

    // Measure each frame and update the lock and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q        <= '0;
            have_start_q <= 1'b0;
            have_meas_q  <= 1'b0;
            ratio_val    <= '0;
            ratio_lock   <= 1'b0;
            ratio_err    <= 1'b0;
        end else if (frame_start) begin
            run_q        <= '0;
            have_start_q <= 1'b1;
            if (have_start_q) begin
                ratio_val   <= meas;
                have_meas_q <= 1'b1;
                ratio_lock  <= ratio_ok(int'(meas)) && have_meas_q && (meas == ratio_val);
                ratio_err   <= !ratio_ok(int'(meas)) || (have_meas_q && (meas != ratio_val));
            end
        end else if (have_start_q) begin
            if (run_q != RATIO_W'(MAX_RATIO)) begin
                run_q <= meas;
            end else begin
                ratio_lock <= 1'b0;
                ratio_err  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sap_slot_deser.sv
// Turns the serial data into left-aligned words, one per slot. A frame start
// loads an offset countdown. When it expires the slot counter restarts at 0
// and the slot and word lengths are taken up, so a word still in flight from
// the previous frame finishes under its own settings.
// Assumes: slot length of at least 1; at most MAX_SLOTS slots are output.
module sap_slot_deser #(
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 6,
    parameter int OFF_W     = 2,
    parameter int MAX_SLOTS = 8,
    localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd,
    input  logic              frame_start,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic [LEN_W-1:0]  cfg_slot_len,
    input  logic [LEN_W-1:0]  cfg_word_len,
    output logic              out_valid,
    output logic [SLOT_W-1:0] out_slot,
    output logic [DATA_W-1:0] out_data,
    output logic [LEN_W-1:0]  slot_len_q,
    output logic [LEN_W-1:0]  word_len_q
);

    logic              pend_q;
    logic [OFF_W-1:0]  rem_q;
    logic              run_q;
    logic [LEN_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic [DATA_W-1:0] acc_q;

    logic              restart;
    logic              live;
    logic              last;
    logic [LEN_W-1:0]  len_use;
    logic [LEN_W-1:0]  wl_use;
    logic [LEN_W-1:0]  bpos;
    logic [SLOT_W-1:0] sidx;
    logic [DATA_W-1:0] acc_nx;

    // The first data bit of a frame is here when the offset has run out.
    assign restart = (frame_start && (cfg_offset == '0)) ||
                     (!frame_start && pend_q && (rem_q == '0));

    // Work out the position and the updated word for this bit.
    always_comb begin
        len_use = restart ? cfg_slot_len : slot_len_q;
        wl_use  = restart ? cfg_word_len : word_len_q;
        bpos    = restart ? '0 : bit_q;
        sidx    = restart ? '0 : slot_q;
        live    = restart || run_q;
        acc_nx  = restart ? '0 : acc_q;
        if ((bpos < wl_use) && (int'(bpos) < DATA_W)) begin
            acc_nx[DATA_W-1-int'(bpos)] = sd;
        end
        last = live && (bpos == len_use - LEN_W'(1));
    end

    // Count down the offset between frame start and first data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rem_q  <= '0;
        end else if (frame_start) begin
            pend_q <= (cfg_offset != '0);
            rem_q  <= cfg_offset - OFF_W'(1);
        end else if (pend_q) begin
            if (rem_q == '0) pend_q <= 1'b0;
            else             rem_q  <= rem_q - OFF_W'(1);
        end
    end

    // Take up the slot and word lengths at the first data bit of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_len_q <= '0;
            word_len_q <= '0;
        end else if (restart) begin
            slot_len_q <= cfg_slot_len;
            word_len_q <= cfg_word_len;
        end
    end

    // Gather bits, step through the slots and output each completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            bit_q     <= '0;
            slot_q    <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_slot  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (live) begin
                if (last) begin
                    out_valid <= 1'b1;
                    out_data  <= acc_nx;
                    out_slot  <= sidx;
                    acc_q     <= '0;
                    bit_q     <= '0;
                    if (sidx == SLOT_W'(MAX_SLOTS - 1)) begin
                        run_q <= 1'b0;
                    end else begin
                        run_q  <= 1'b1;
                        slot_q <= sidx + SLOT_W'(1);
                    end
                end else begin
                    run_q  <= 1'b1;
                    acc_q  <= acc_nx;
                    bit_q  <= bpos + LEN_W'(1);
                    slot_q <= sidx;
                end
            end
        end
    end

endmodule

// File: rtl/sap_rx.sv
// Top of the serial audio receiver: edge and frame-start capture, slot
// deserialiser and frame-ratio meter, all clocked by the bit clock.
// Assumes: the bit clock is free-running while reset is applied.
module sap_rx
    import sap_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 6,
    parameter int OFF_W     = 2,
    parameter int MAX_SLOTS = 8,
    parameter int RATIO_W   = 9,
    parameter int MAX_RATIO = 256,
    localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic               bclk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic               sdata,
    input  logic               cfg_fall_edge,
    input  logic               cfg_fs_rise,
    input  logic [OFF_W-1:0]   cfg_offset,
    input  logic [LEN_W-1:0]   cfg_slot_len,
    input  logic [LEN_W-1:0]   cfg_word_len,
    output logic               smp_valid,
    output logic [SLOT_W-1:0]  smp_slot,
    output logic [DATA_W-1:0]  smp_data,
    output logic [RATIO_W-1:0] ratio_val,
    output logic               ratio_lock,
    output logic               ratio_err
);

    sap_bit_t         cur;
    logic             frame_start;
    logic [LEN_W-1:0] sl_q;
    logic [LEN_W-1:0] wl_q;

    sap_bit_capture u_cap (
        .clk         (bclk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .sdata       (sdata),
        .fall_edge   (cfg_fall_edge),
        .fs_rise     (cfg_fs_rise),
        .cur         (cur),
        .frame_start (frame_start)
    );

    sap_slot_deser #(
        .DATA_W    (DATA_W),
        .LEN_W     (LEN_W),
        .OFF_W     (OFF_W),
        .MAX_SLOTS (MAX_SLOTS)
    ) u_deser (
        .clk          (bclk),
        .rst_n        (rst_n),
        .sd           (cur.sd),
        .frame_start  (frame_start),
        .cfg_offset   (cfg_offset),
        .cfg_slot_len (cfg_slot_len),
        .cfg_word_len (cfg_word_len),
        .out_valid    (smp_valid),
        .out_slot     (smp_slot),
        .out_data     (smp_data),
        .slot_len_q   (sl_q),
        .word_len_q   (wl_q)
    );

    sap_ratio_meter #(
        .RATIO_W   (RATIO_W),
        .MAX_RATIO (MAX_RATIO)
    ) u_ratio (
        .clk         (bclk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .ratio_val   (ratio_val),
        .ratio_lock  (ratio_lock),
        .ratio_err   (ratio_err)
    );

endmodule

// File: rtl/sap_rx_chk.sv
// Property checker for sap_rx, attached through bind. It watches the output
// ports and the slot and word lengths the deserialiser has taken up.
module sap_rx_chk
    import sap_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 6,
    parameter int RATIO_W   = 9,
    parameter int SLOT_W    = 3
) (
    input logic               bclk,
    input logic               rst_n,
    input logic               smp_valid,
    input logic [SLOT_W-1:0]  smp_slot,
    input logic [DATA_W-1:0]  smp_data,
    input logic [RATIO_W-1:0] ratio_val,
    input logic               ratio_lock,
    input logic               ratio_err,
    input logic [LEN_W-1:0]   sl_q,
    input logic [LEN_W-1:0]   wl_q
);

    logic              rst_q;
    logic [DATA_W-1:0] low_mask;

    // Low bits that must be zero for the word length in use.
    assign low_mask = {DATA_W{1'b1}} >> wl_q;

    // Outputs are at their reset values one edge after reset was sampled low.
    always @(posedge bclk) begin
        rst_q <= rst_n;
        if (rst_q == 1'b0) begin
            assert_reset_R1: assert (!smp_valid && !ratio_lock && !ratio_err && ratio_val == '0)
                else $error("outputs not cleared by reset");
        end
    end

    // Bits past the word length stay zero.
    assert_lowbits_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        smp_valid |-> ((smp_data & low_mask) == '0));

    // One strobe per slot when slots are longer than one bit.
    assert_single_strobe_R8: assert property (@(posedge bclk) disable iff (!rst_n)
        (smp_valid && sl_q >= LEN_W'(2)) |=> (!smp_valid || sl_q < LEN_W'(2)));

    // Lock is only reported on a supported ratio.
    assert_lock_supported_R9: assert property (@(posedge bclk) disable iff (!rst_n)
        ratio_lock |-> ratio_ok(int'(ratio_val)));

    // Lock rises only when the new count repeats the previous one.
    assert_lock_repeat_R9: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(ratio_lock) |-> $stable(ratio_val));

    // Lock and error never coexist.
    assert_lock_err_excl_R11: assert property (@(posedge bclk) disable iff (!rst_n)
        ratio_lock |-> !ratio_err);

    // Slot index of a strobe is well defined.
    assert_slot_known_R7: assert property (@(posedge bclk) disable iff (!rst_n)
        smp_valid |-> !$isunknown(smp_slot));

endmodule

bind sap_rx sap_rx_chk #(
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W),
    .RATIO_W (RATIO_W),
    .SLOT_W  (SLOT_W)
) u_chk (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_slot   (smp_slot),
    .smp_data   (smp_data),
    .ratio_val  (ratio_val),
    .ratio_lock (ratio_lock),
    .ratio_err  (ratio_err),
    .sl_q       (sl_q),
    .wl_q       (wl_q)
);

// File: tb/sap_rx_tb.sv
module sap_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LEAD       = 2;
    localparam int MAXREC     = 256;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic        cfg_fall_edge = 1'b0;
    logic        cfg_fs_rise = 1'b0;
    logic [1:0]  cfg_offset = 2'd1;
    logic [5:0]  cfg_slot_len = 6'd24;
    logic [5:0]  cfg_word_len = 6'd24;
    logic        smp_valid;
    logic [2:0]  smp_slot;
    logic [31:0] smp_data;
    logic [8:0]  ratio_val;
    logic        ratio_lock;
    logic        ratio_err;

    int errors = 0;
    int checks = 0;

    logic [31:0] rec_data [MAXREC];
    logic [2:0]  rec_slot [MAXREC];
    int          rec_cnt = 0;
    int          dbl_cnt = 0;
    logic        prev_v = 1'b0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    sap_rx u_dut (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .fsync         (fsync),
        .sdata         (sdata),
        .cfg_fall_edge (cfg_fall_edge),
        .cfg_fs_rise   (cfg_fs_rise),
        .cfg_offset    (cfg_offset),
        .cfg_slot_len  (cfg_slot_len),
        .cfg_word_len  (cfg_word_len),
        .smp_valid     (smp_valid),
        .smp_slot      (smp_slot),
        .smp_data      (smp_data),
        .ratio_val     (ratio_val),
        .ratio_lock    (ratio_lock),
        .ratio_err     (ratio_err)
    );

    // Record every sample strobe, away from the rising edge.
    always @(negedge bclk) begin
        if (rst_n && smp_valid) begin
            if (rec_cnt < MAXREC) begin
                rec_data[rec_cnt] = smp_data;
                rec_slot[rec_cnt] = smp_slot;
            end
            rec_cnt = rec_cnt + 1;
            if (prev_v) dbl_cnt = dbl_cnt + 1;
        end
        prev_v = rst_n && smp_valid;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int f, input int s);
        logic [31:0] x;
        x = 32'(f * 8 + s + 1) * 32'h9E37_79B9;
        return x ^ (x >> 13) ^ 32'h5A00_00A5;
    endfunction

    // Expected left-aligned word: bits past tx length were sent as ones.
    function automatic logic [31:0] expw(input int f, input int s, input int txwl, input int rxwl);
        logic [31:0] p;
        logic [31:0] w;
        p = pat(f, s);
        w = '0;
        for (int b = 0; b < 32; b++) begin
            if (b < rxwl) w[31-b] = (b < txwl) ? p[31-b] : 1'b1;
        end
        return w;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        fsync = 1'b0;
        sdata = 1'b0;
        repeat (3) @(posedge bclk);
        @(negedge bclk);
        rst_n = 1'b1;
    endtask

    // Drive a stream of frames; the bit position runs across frame borders.
    task automatic send_stream(input int n, input int slen, input int txwl, input int off,
                               input bit pulse, input bit pol, input bit fall,
                               input int nfr, input int tail, input int chg_at, input int chg_wl);
        int total;
        total = LEAD + nfr * n + tail;
        for (int g = 0; g < total; g++) begin
            logic fs_v;
            logic sd_v;
            if (g == chg_at) cfg_word_len = 6'(chg_wl);
            if (g < LEAD) begin
                fs_v = ~pol;
                sd_v = 1'b0;
            end else begin
                int h;
                int q;
                h = g - LEAD;
                if (pulse) fs_v = ((h % n) == 0) ? pol : ~pol;
                else       fs_v = ((h % n) < n / 2) ? pol : ~pol;
                q = h - off;
                sd_v = 1'b0;
                if (q >= 0) begin
                    int f;
                    int r;
                    int s;
                    int b;
                    logic [31:0] p;
                    f = q / n;
                    r = q % n;
                    s = r / slen;
                    b = r % slen;
                    p = pat(f, s);
                    if (s < n / slen) sd_v = (b < txwl) ? p[31-b] : 1'b1;
                end
            end
            if (fall) begin
                @(posedge bclk);
                #1;
            end else begin
                @(negedge bclk);
            end
            fsync = fs_v;
            sdata = sd_v;
        end
        repeat (4) @(negedge bclk);
    endtask

    // Compare recorded words of the first nfr frames against expectations.
    task automatic check_words(input string req, input int base, input int nfr, input int n,
                               input int slen, input int txwl, input int rxwl0,
                               input int rxwl1, input int chg_frame);
        int per;
        int k;
        per = n / slen;
        if (per > 8) per = 8;
        chk(req, "enough samples", 32'(rec_cnt - base >= nfr * per), 32'd1);
        k = base;
        for (int f = 0; f < nfr; f++) begin
            for (int s = 0; s < per; s++) begin
                if (k < rec_cnt && k < MAXREC) begin
                    chk(req, "sample word", rec_data[k], expw(f, s, txwl, (f >= chg_frame) ? rxwl1 : rxwl0));
                    chk(req, "slot index", 32'(rec_slot[k]), 32'(s));
                end
                k++;
            end
        end
    endtask

    task automatic set_cfg(input bit fall, input bit rise, input int off, input int slen, input int wl);
        cfg_fall_edge = fall;
        cfg_fs_rise   = rise;
        cfg_offset    = 2'(off);
        cfg_slot_len  = 6'(slen);
        cfg_word_len  = 6'(wl);
    endtask

    task automatic test_reset();
        int base;
        set_cfg(0, 1, 0, 24, 24);
        do_reset();
        chk("R1", "valid after reset", 32'(smp_valid), 32'd0);
        chk("R1", "lock after reset", 32'(ratio_lock), 32'd0);
        chk("R1", "err after reset", 32'(ratio_err), 32'd0);
        chk("R1", "ratio after reset", 32'(ratio_val), 32'd0);
        base = rec_cnt;
        fsync = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge bclk);
            sdata = i[0];
        end
        chk("R1", "no samples without frame start", 32'(rec_cnt - base), 32'd0);
    endtask

    task automatic test_i2s();
        int base;
        int dbl0;
        set_cfg(0, 0, 1, 24, 24);
        do_reset();
        base = rec_cnt;
        dbl0 = dbl_cnt;
        send_stream(48, 24, 24, 1, 0, 0, 0, 3, 48, -1, 0);
        check_words("R2", base, 3, 48, 24, 24, 24, 24, 99);
        chk("R8", "strobes in consecutive clocks", 32'(dbl_cnt - dbl0), 32'd0);
        chk("R9", "ratio value", 32'(ratio_val), 32'd48);
        chk("R9", "lock", 32'(ratio_lock), 32'd1);
        chk("R9", "err", 32'(ratio_err), 32'd0);
    endtask

    task automatic test_fall();
        int base;
        set_cfg(1, 0, 1, 24, 24);
        do_reset();
        base = rec_cnt;
        send_stream(48, 24, 24, 1, 0, 0, 1, 3, 48, -1, 0);
        check_words("R3", base, 3, 48, 24, 24, 24, 24, 99);
    endtask

    task automatic test_lj();
        int base;
        set_cfg(0, 1, 0, 24, 24);
        do_reset();
        base = rec_cnt;
        send_stream(48, 24, 24, 0, 0, 1, 0, 3, 48, -1, 0);
        check_words("R4", base, 3, 48, 24, 24, 24, 24, 99);
    endtask

    task automatic test_off2();
        int base;
        set_cfg(0, 1, 2, 32, 32);
        do_reset();
        base = rec_cnt;
        send_stream(64, 32, 32, 2, 1, 1, 0, 3, 64, -1, 0);
        check_words("R5", base, 3, 64, 32, 32, 32, 32, 99);
    endtask

    task automatic test_wordlen();
        int base;
        set_cfg(0, 0, 1, 32, 16);
        do_reset();
        base = rec_cnt;
        send_stream(64, 32, 20, 1, 0, 0, 0, 3, 64, -1, 0);
        check_words("R6", base, 3, 64, 32, 20, 16, 16, 99);
    endtask

    task automatic test_tdm();
        int base;
        set_cfg(0, 1, 1, 16, 16);
        do_reset();
        base = rec_cnt;
        send_stream(128, 16, 16, 1, 1, 1, 0, 2, 128, -1, 0);
        check_words("R7", base, 2, 128, 16, 16, 16, 16, 99);
        chk("R9", "ratio 128 lock", 32'(ratio_lock), 32'd1);
    endtask

    task automatic test_maxslots();
        int base;
        set_cfg(0, 1, 0, 16, 16);
        do_reset();
        base = rec_cnt;
        send_stream(256, 16, 16, 0, 1, 1, 0, 3, 4, -1, 0);
        check_words("R13", base, 3, 256, 16, 16, 16, 16, 99);
        chk("R13", "samples per three frames", 32'(rec_cnt - base), 32'd24);
    endtask

    task automatic test_unsupported();
        set_cfg(0, 0, 1, 20, 20);
        do_reset();
        send_stream(40, 20, 20, 1, 0, 0, 0, 3, 1, -1, 0);
        chk("R10", "ratio value", 32'(ratio_val), 32'd40);
        chk("R10", "err", 32'(ratio_err), 32'd1);
        chk("R10", "no lock", 32'(ratio_lock), 32'd0);
    endtask

    task automatic test_change();
        set_cfg(0, 0, 1, 24, 24);
        do_reset();
        send_stream(48, 24, 24, 1, 0, 0, 0, 3, 1, -1, 0);
        chk("R11", "lock before change", 32'(ratio_lock), 32'd1);
        send_stream(64, 32, 32, 1, 0, 0, 0, 1, 1, -1, 0);
        chk("R11", "ratio after change", 32'(ratio_val), 32'd64);
        chk("R11", "err after change", 32'(ratio_err), 32'd1);
        chk("R11", "lock dropped", 32'(ratio_lock), 32'd0);
    endtask

    task automatic test_cfgchg();
        int base;
        set_cfg(0, 0, 1, 24, 24);
        do_reset();
        base = rec_cnt;
        send_stream(48, 24, 24, 1, 0, 0, 0, 3, 48, LEAD + 10, 16);
        check_words("R12", base, 3, 48, 24, 24, 24, 16, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_i2s();
        test_fall();
        test_lj();
        test_off2();
        test_wordlen();
        test_tdm();
        test_maxslots();
        test_unsupported();
        test_change();
        test_cfgchg();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule